// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor's load/store port and a word-beat memory port. It keeps 1K 32-bit words as 256 lines of four words each, with one valid bit, one dirty bit and a 20-bit tag per line. Loads and stores that hit are served from the local data array. A store hit updates only the addressed word and marks the line dirty, so memory holds stale data until the line leaves.

On a miss, the controller stalls the processor. If the line it must replace is dirty, it first writes that line's four words out, starting from word 0. It then reads the four words of the new block, starting from word 0. A store miss merges its word into the block as it arrives. After that, the controller completes the original access. One access therefore moves zero, one or two blocks across the memory port.

The processor holds `cpu_req` and its operands steady until it sees `cpu_ack`. Each memory beat is a `mem_req` that stays steady until the memory answers with a one-cycle `mem_ack`.

Top module: `wbwa_cache`

## Requirements
- R1: After reset every line is invalid and clean. The first access to any address refills four words and writes nothing back, even if that line was dirty before the reset. In the reset state `cpu_ack`, `cpu_stall` and `mem_req` are all 0.
- R2: The address is split into fields as follows: bits [3:2] pick the word, bits [11:4] pick the line, and bits [31:12] form the tag. Two addresses with the same line field but different tags evict each other.
- R3: A load hit returns the stored word with `cpu_ack` high in the cycle after the request is taken, with no memory beat.
- R4: A store hit writes only the addressed word and marks the line dirty, with no memory beat. The other three words of the line keep their values.
- R5: A store miss refills the whole block, then writes the store word over the refilled word and marks the line dirty.
- R6: A miss whose victim line is clean or invalid makes exactly four read beats. These beats go to the new block's word addresses in ascending order, starting at offset 0. Each beat holds its address and direction until it is acknowledged.
- R7: A miss whose victim line is dirty first makes four write beats. These carry the victim's current cache words to the addresses built from the victim's tag and line, word 0 first. The four read beats of R6 follow.
- R8: A load miss returns the requested word after the refill has finished. The refilled line is clean, so a later eviction of it makes no write beats.
- R9: `cpu_stall` is high in every cycle between miss detection and completion, and low in the cycle where `cpu_ack` is high. `cpu_ack` is a single-cycle pulse.
- R10: Address bits [1:0] have no effect: any byte address inside a word reaches that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while `cpu_ack` is high |
| cpu_ack | output | 1 | Access complete, one cycle |
| cpu_stall | output | 1 | Miss handling in progress |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | 32 | Word-aligned byte address of the beat |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data, valid with `mem_ack` |
| mem_ack | input | 1 | Beat accepted, one cycle |

## Verification
The main function is exercised by a sequence of loads and stores aimed at a few chosen lines. The sequence mixes hits on every word of a line, clean evictions, dirty evictions, and a store miss whose victim is itself dirty. Counting read and write beats for each access separates the zero-, one- and two-transfer cases. The beat addresses separate the victim tag from the new tag. Reloading a line that was written back shows whether memory received the dirty data, and a load with a nonzero byte offset or to a neighbouring word shows whether field decoding and single-word store merging are correct. A final reset in the middle of the run, made while a line is dirty, shows that no write-back survives the reset.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2,
    ST_DONE  = 2'd3
  } cwb_state_e;
endpackage

// File: rtl/cwb_data_ram.sv
module cwb_data_ram #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] dout
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    dout <= mem[raddr];
  end
endmodule

// File: rtl/cwb_tag_store.sv
module cwb_tag_store #(
  parameter int LINES = 256,
  parameter int TAG_W = 20,
  localparam int IW   = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IW-1:0]    rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic [IW-1:0]    wr_idx,
  input  logic             set_dirty,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_dirty
);
  logic [LINES-1:0] valid_r;
  logic [LINES-1:0] dirty_r;
  logic [TAG_W-1:0] tag_r [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel;
    assign sel = (wr_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_r[g] <= 1'b0;
        dirty_r[g] <= 1'b0;
      end else if (sel && fill_en) begin
        valid_r[g] <= 1'b1;
        dirty_r[g] <= fill_dirty;
      end else if (sel && set_dirty) begin
        dirty_r[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_r[wr_idx] <= fill_tag;
  end

  assign rd_valid = valid_r[rd_idx];
  assign rd_dirty = dirty_r[rd_idx];
  assign rd_tag   = tag_r[rd_idx];

  // R4: a dirty line must always be a resident one
  assert_dirty_implies_valid_R4: assert property (@(posedge clk) disable iff (rst)
    rd_dirty |-> rd_valid);
endmodule

// File: rtl/cwb_ctrl.sv
module cwb_ctrl
  import cwb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int LINES     = 256,
  parameter int BLK_WORDS = 4,
  localparam int IDX_W    = $clog2(LINES),
  localparam int OFS_W    = $clog2(BLK_WORDS),
  localparam int BYTE_W   = $clog2(WORD_W / 8),
  localparam int TAG_W    = ADDR_W - IDX_W - OFS_W - BYTE_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cpu_req,
  input  logic                   cpu_we,
  input  logic [ADDR_W-1:0]      cpu_addr,
  input  logic [WORD_W-1:0]      cpu_wdata,
  output logic [WORD_W-1:0]      cpu_rdata,
  output logic                   cpu_ack,
  output logic                   cpu_stall,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [WORD_W-1:0]      mem_wdata,
  input  logic [WORD_W-1:0]      mem_rdata,
  input  logic                   mem_ack,
  output logic [IDX_W-1:0]       lk_idx,
  input  logic                   lk_valid,
  input  logic                   lk_dirty,
  input  logic [TAG_W-1:0]       lk_tag,
  output logic [IDX_W-1:0]       ts_idx,
  output logic                   ts_set_dirty,
  output logic                   ts_fill,
  output logic [TAG_W-1:0]       ts_tag,
  output logic                   ts_fill_dirty,
  output logic                   ram_we,
  output logic [IDX_W+OFS_W-1:0] ram_waddr,
  output logic [WORD_W-1:0]      ram_wdata,
  output logic [IDX_W+OFS_W-1:0] ram_raddr,
  input  logic [WORD_W-1:0]      ram_dout
);
  localparam logic [OFS_W-1:0] LAST_BEAT = OFS_W'(BLK_WORDS - 1);

  cwb_state_e state;
  logic [TAG_W-1:0]  q_tag, v_tag;
  logic [IDX_W-1:0]  q_idx;
  logic [OFS_W-1:0]  q_word, beat;
  logic [WORD_W-1:0] q_wdata, fill_word;
  logic              q_we, wb_vld, from_fill;

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [OFS_W-1:0]  a_word;
  logic              unused_byte_bits;
  logic              hit, take_hit, take_miss, beat_fire;

  assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign a_idx  = cpu_addr[BYTE_W+OFS_W +: IDX_W];
  assign a_word = cpu_addr[BYTE_W +: OFS_W];
  assign unused_byte_bits = ^cpu_addr[BYTE_W-1:0];

  assign lk_idx    = a_idx;
  assign hit       = lk_valid && (lk_tag == a_tag);
  assign take_hit  = (state == ST_IDLE) && cpu_req && hit;
  assign take_miss = (state == ST_IDLE) && cpu_req && !hit;

  assign mem_req   = ((state == ST_EVICT) && wb_vld) || (state == ST_FILL);
  assign mem_we    = (state == ST_EVICT);
  assign mem_addr  = {(state == ST_EVICT) ? v_tag : q_tag, q_idx, beat, {BYTE_W{1'b0}}};
  assign mem_wdata = ram_dout;
  assign beat_fire = mem_req && mem_ack;

  assign ts_tag        = q_tag;
  assign ts_fill_dirty = q_we;
  assign ram_raddr     = (state == ST_EVICT) ? {q_idx, beat} : {a_idx, a_word};

  always_comb begin
    ram_we       = 1'b0;
    ram_waddr    = {a_idx, a_word};
    ram_wdata    = cpu_wdata;
    ts_idx       = a_idx;
    ts_set_dirty = 1'b0;
    ts_fill      = 1'b0;
    fill_word    = (q_we && beat == q_word) ? q_wdata : mem_rdata;
    if (take_hit && cpu_we) begin
      ram_we       = 1'b1;
      ts_set_dirty = 1'b1;
    end
    if (state == ST_FILL && beat_fire) begin
      ram_we    = 1'b1;
      ram_waddr = {q_idx, beat};
      ram_wdata = fill_word;
      ts_idx    = q_idx;
      ts_fill   = (beat == LAST_BEAT);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      beat      <= '0;
      wb_vld    <= 1'b0;
      from_fill <= 1'b0;
      q_we      <= 1'b0;
      q_tag     <= '0;
      v_tag     <= '0;
      q_idx     <= '0;
      q_word    <= '0;
      q_wdata   <= '0;
      cpu_rdata <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take_hit) begin
            from_fill <= 1'b0;
            state     <= ST_DONE;
          end else if (take_miss) begin
            q_we    <= cpu_we;
            q_tag   <= a_tag;
            q_idx   <= a_idx;
            q_word  <= a_word;
            q_wdata <= cpu_wdata;
            v_tag   <= lk_tag;
            beat    <= '0;
            wb_vld  <= 1'b0;
            state   <= (lk_valid && lk_dirty) ? ST_EVICT : ST_FILL;
          end
        end
        ST_EVICT: begin
          wb_vld <= !beat_fire;
          if (beat_fire) begin
            beat <= beat + 1'b1;
            if (beat == LAST_BEAT) state <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (beat_fire) begin
            beat <= beat + 1'b1;
            if (!q_we && beat == q_word) cpu_rdata <= mem_rdata;
            if (beat == LAST_BEAT) begin
              from_fill <= 1'b1;
              state     <= ST_DONE;
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // The hit path reads straight from the data array; the miss path uses the captured refill word
  logic [WORD_W-1:0] fill_rdata;
  assign fill_rdata = cpu_rdata;

  assign cpu_ack   = (state == ST_DONE);
  assign cpu_stall = (state == ST_EVICT) || (state == ST_FILL);

  // R3: a request that hits is acknowledged on the next cycle
  assert_hit_acks_next_R3: assert property (@(posedge clk) disable iff (rst)
    take_hit |=> cpu_ack);
  // R9: the acknowledge is one cycle wide and never overlaps the stall
  assert_ack_single_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);
  assert_ack_unstalled_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |-> !cpu_stall);
  // R6: an unanswered beat keeps its address and direction
  assert_beat_held_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: rtl/wbwa_cache.sv
module wbwa_cache #(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int LINES     = 256,
  parameter int BLK_WORDS = 4,
  localparam int IDX_W    = $clog2(LINES),
  localparam int OFS_W    = $clog2(BLK_WORDS),
  localparam int BYTE_W   = $clog2(WORD_W / 8),
  localparam int TAG_W    = ADDR_W - IDX_W - OFS_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ack,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  logic [IDX_W-1:0]       lk_idx, ts_idx;
  logic                   lk_valid, lk_dirty, ts_set_dirty, ts_fill, ts_fill_dirty;
  logic [TAG_W-1:0]       lk_tag, ts_tag;
  logic                   ram_we;
  logic [IDX_W+OFS_W-1:0] ram_waddr, ram_raddr;
  logic [WORD_W-1:0]      ram_wdata, ram_dout, fill_rdata;
  logic                   from_fill;

  cwb_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINES(LINES), .BLK_WORDS(BLK_WORDS)) u_ctrl (
    .clk, .rst, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata,
    .cpu_rdata(fill_rdata), .cpu_ack, .cpu_stall,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack,
    .lk_idx, .lk_valid, .lk_dirty, .lk_tag,
    .ts_idx, .ts_set_dirty, .ts_fill, .ts_tag, .ts_fill_dirty,
    .ram_we, .ram_waddr, .ram_wdata, .ram_raddr, .ram_dout
  );

  cwb_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk, .rst,
    .rd_idx(lk_idx), .rd_valid(lk_valid), .rd_dirty(lk_dirty), .rd_tag(lk_tag),
    .wr_idx(ts_idx), .set_dirty(ts_set_dirty), .fill_en(ts_fill),
    .fill_tag(ts_tag), .fill_dirty(ts_fill_dirty)
  );

  cwb_data_ram #(.WORD_W(WORD_W), .DEPTH(LINES * BLK_WORDS)) u_data (
    .clk, .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .dout(ram_dout)
  );

  // Remember which path completed the access so the right word is presented
  always_ff @(posedge clk) begin
    if (rst)                 from_fill <= 1'b0;
    else if (ts_fill)        from_fill <= 1'b1;
    else if (cpu_ack)        from_fill <= 1'b0;
  end

  assign cpu_rdata = from_fill ? fill_rdata : ram_dout;
endmodule

// File: tb/sim_wbwa_cache.sv
`timescale 1ns/1ps
module sim_wbwa_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ack, cpu_stall;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #4 clk = ~clk;

  wbwa_cache u0 (.*);

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic [31:0] back_mem [4096];
  logic [31:0] ref_mem  [4096];
  int          n_rd, n_wr;
  logic [31:0] rd_log [8];
  logic [31:0] wr_log [8];
  logic [31:0] wd_log [8];

  function automatic logic [31:0] pat(int i);
    return 32'hA000_0000 ^ (i * 32'h0001_0003);
  endfunction

  // memory model: answers one beat per request, one cycle later
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        back_mem[mem_addr[13:2]] = mem_wdata;
        if (n_wr < 8) begin wr_log[n_wr] = mem_addr; wd_log[n_wr] = mem_wdata; end
        n_wr++;
      end else begin
        mem_rdata = back_mem[mem_addr[13:2]];
        if (n_rd < 8) rd_log[n_rd] = mem_addr;
        n_rd++;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat, output bit saw_stall);
    @(negedge clk);
    n_rd = 0; n_wr = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    lat = 0; saw_stall = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (cpu_stall) saw_stall = 1;
      if (cpu_ack) break;
      if (lat > 400) break;
    end
    chk("R9", "stall low at ack", {31'b0, cpu_stall}, 32'd0);
    rd = cpu_rdata;
    cpu_req = 1'b0;
    if (we) ref_mem[a[13:2]] = d;
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] wb_base;
    logic [3:0]  n_rd;
    logic [3:0]  n_wr;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{1'b0, 32'h0000_0040, 32'h0,          32'h0,          4'd4, 4'd0}, // R1 cold miss
    '{1'b0, 32'h0000_0048, 32'h0,          32'h0,          4'd0, 4'd0}, // R3 hit other word
    '{1'b1, 32'h0000_0044, 32'hDEAD_0001,  32'h0,          4'd0, 4'd0}, // R4 store hit
    '{1'b0, 32'h0000_0044, 32'h0,          32'h0,          4'd0, 4'd0}, // R4 read back
    '{1'b0, 32'h0000_1040, 32'h0,          32'h0000_0040,  4'd4, 4'd4}, // R2 R7 dirty conflict
    '{1'b0, 32'h0000_0044, 32'h0,          32'h0,          4'd4, 4'd0}, // R8 clean victim
    '{1'b1, 32'h0000_2084, 32'hBEEF_0002,  32'h0,          4'd4, 4'd0}, // R5 store miss
    '{1'b0, 32'h0000_2087, 32'h0,          32'h0,          4'd0, 4'd0}, // R10 byte offset
    '{1'b0, 32'h0000_2088, 32'h0,          32'h0,          4'd0, 4'd0}, // R4 neighbour kept
    '{1'b1, 32'h0000_0F0C, 32'h1234_0003,  32'h0,          4'd4, 4'd0}, // R5
    '{1'b1, 32'h0000_1F0C, 32'h5678_0004,  32'h0000_0F00,  4'd4, 4'd4}, // R7 store miss dirty
    '{1'b0, 32'h0000_0F0C, 32'h0,          32'h0000_1F00,  4'd4, 4'd4}, // R7 R8
    '{1'b0, 32'h0000_0040, 32'h0,          32'h0,          4'd0, 4'd0}, // R3
    '{1'b0, 32'h0000_3040, 32'h0,          32'h0,          4'd4, 4'd0}  // R8 clean evict
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int lat;
    bit st;
    for (int i = 0; i < 4096; i++) begin back_mem[i] = pat(i); ref_mem[i] = pat(i); end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "ack in reset", {31'b0, cpu_ack}, 32'd0);
    chk("R1", "stall in reset", {31'b0, cpu_stall}, 32'd0);
    chk("R1", "mem_req in reset", {31'b0, mem_req}, 32'd0);
    rst = 1'b0;

    for (int v = 0; v < 14; v++) begin
      vec_t e;
      logic [31:0] base;
      e = VEC[v];
      base = {e.addr[31:4], 4'h0};
      access(e.we, e.addr, e.wdata, rd, lat, st);
      chk("R6", $sformatf("v%0d read beats", v), n_rd, {28'b0, e.n_rd});
      chk("R7", $sformatf("v%0d write beats", v), n_wr, {28'b0, e.n_wr});
      if (!e.we) chk("R8", $sformatf("v%0d load data", v), rd, ref_mem[e.addr[13:2]]);
      if (e.n_rd == 0 && e.n_wr == 0)
        chk("R3", $sformatf("v%0d hit latency", v), lat, 32'd1);
      else
        chk("R9", $sformatf("v%0d stall seen", v), {31'b0, st}, 32'd1);
      if (e.n_rd == 4)
        for (int k = 0; k < 4; k++)
          chk("R6", $sformatf("v%0d refill addr %0d", v, k), rd_log[k], base + 32'(4 * k));
      if (e.n_wr == 4)
        for (int k = 0; k < 4; k++) begin
          chk("R7", $sformatf("v%0d wb addr %0d", v, k), wr_log[k], e.wb_base + 32'(4 * k));
          chk("R7", $sformatf("v%0d wb data %0d", v, k), wd_log[k], ref_mem[e.wb_base[13:2] + 12'(k)]);
        end
    end

    // R5: merged store word reached memory after its eviction in the table
    chk("R5", "merged word in memory", back_mem[12'h3C3], 32'h1234_0003);

    // R1: reset discards a dirty line without write-back
    access(1'b1, 32'h0000_3048, 32'hCAFE_0005, rd, lat, st);
    chk("R4", "store hit no beats", n_rd + n_wr, 32'd0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    access(1'b0, 32'h0000_0048, 32'h0, rd, lat, st);
    chk("R1", "no write-back after reset", n_wr, 32'd0);
    chk("R1", "refill after reset", n_rd, 32'd4);
    chk("R2", "reload data", rd, back_mem[12'h012]);
    finish_run();
  end
endmodule